// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block holds the two physical stack pointers of a small processor core, a main pointer and a process pointer, along with a three-bit control register. The control register picks which pointer thread code uses and whether thread code runs privileged. Handler mode always uses the main pointer and always runs privileged. Software sees one register port. Through it, it reads or writes either pointer directly, the currently selected pointer through an alias, the control register, and an optional pair of stack limit registers.

Thread privilege is kept in a two-state machine. `LVL_PRIV` is the reset state. The transition `PRIV_TO_USER` is taken on any control write that sets bit 0 while privileged. The transition `USER_TO_PRIV` is taken only on a control write that clears bit 0 while the core is in handler mode. As a result, thread code that has dropped to `LVL_USER` cannot climb back by itself.

When the limit feature is enabled, a write to the active pointer with a value below that pointer's limit raises a violation pulse. When the feature is built out, the limit registers read as zero, ignore writes and never raise a violation.

Top module: `sp_bank_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, the main pointer takes `reset_vector` with its two low bits cleared. The control bits become 0, the privilege state becomes `LVL_PRIV` and `limit_fault` becomes 0, so `privileged` reads 1 after reset.
- R2: While `handler_mode` is 1, `cur_sp` shows the main pointer, whatever the control bits hold.
- R3: While `handler_mode` is 0, control bit 1 selects the pointer: 0 gives the main pointer and 1 gives the process pointer on `cur_sp`.
- R4: Every pointer write stores the data with bits [1:0] forced to zero. A write to the alias (select 2) lands in whichever pointer is selected in that cycle.
- R5: `privileged` is 1 when `handler_mode` is 1 or control bit 0 is 0, and is 0 otherwise.
- R6: A control write changes bit 1 only in thread mode while privileged. In every other case bit 1 keeps its value.
- R7: A control write changes bit 0 (1 = thread runs as user) and bit 2 (1 = floating-point state active) only while privileged. In user thread state, a control write has no effect at all. Only a write made in handler mode can clear bit 0.
- R8: Register select codes are 0 main pointer, 1 process pointer, 2 current-pointer alias, 3 control (bits [2:0], upper bits zero), 4 main limit and 5 process limit. Codes 6 and 7 read as zero and ignore writes. Read data depends combinationally on `rd_sel` and the current state.
- R9: With limits present, `limit_fault` is 1 for exactly the cycle after a write to the active pointer whose aligned value is strictly below that pointer's limit. A write equal to the limit, or a write to the inactive pointer, gives no pulse.
- R10: With `LIMITS_EN` = 0, selects 4 and 5 read zero, writes to them are ignored, and `limit_fault` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| reset_vector | input | DATA_W | First vector table word, loaded into the main pointer during reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select (see R8) |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 3 | Read register select (see R8) |
| rd_data | output | DATA_W | Read data |
| cur_sp | output | DATA_W | Currently selected stack pointer |
| ctrl_bits | output | 3 | Control register: bit 2 FP active, bit 1 process select, bit 0 user |
| privileged | output | 1 | Current execution is privileged |
| limit_fault | output | 1 | One-cycle stack limit violation pulse |

## Verification
The bench attacks the privilege ratchet: a user thread tries to clear bit 0 and to set bit 2. A design that gated those writes on mode alone would let a thread regain privilege. It writes control bit 1 from handler mode, which a loose write gate would let silently redirect the thread stack. It writes the alias in both modes, to catch a design that decodes the alias from the control bit alone and corrupts the process pointer inside handlers. On the limit side, it checks the equal-to-limit boundary, a below-limit write to the inactive pointer, and the pulse dropping in the following cycle. An off-by-one comparator or a sticky flag shows up as a false or lingering fault. A second copy built without limits must read zero and stay silent.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
    typedef enum logic [2:0] {
        SEL_MAIN = 3'd0,
        SEL_PROC = 3'd1,
        SEL_CUR  = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_MLIM = 3'd4,
        SEL_PLIM = 3'd5
    } reg_sel_e;

    typedef enum logic {
        LVL_PRIV = 1'b0,
        LVL_USER = 1'b1
    } priv_lvl_e;

    localparam int CTRL_W = 3;
endpackage

// File: rtl/sp_ctrl_fsm.sv
module sp_ctrl_fsm
    import sp_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handler_mode,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic              privileged,
    output logic              use_proc
);
    priv_lvl_e state_q, state_d;
    logic      sel_q;
    logic      fp_q;
    logic      may_write;

    // privilege state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_PRIV;
        else        state_q <= state_d;
    end

    // next-state: PRIV_TO_USER and USER_TO_PRIV
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_PRIV: if (ctrl_we && ctrl_wdata[0]) state_d = LVL_USER;
            LVL_USER: if (ctrl_we && handler_mode && !ctrl_wdata[0]) state_d = LVL_PRIV;
            default:  state_d = state_q;
        endcase
    end

    assign may_write = handler_mode || (state_q == LVL_PRIV);

    // pointer-select and FP bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            fp_q  <= 1'b0;
        end else if (ctrl_we) begin
            if (!handler_mode && state_q == LVL_PRIV) sel_q <= ctrl_wdata[1];
            if (may_write)                            fp_q  <= ctrl_wdata[2];
        end
    end

    // outputs
    always_comb begin
        privileged = may_write;
        use_proc   = !handler_mode && sel_q;
        ctrl_bits  = {fp_q, sel_q, (state_q == LVL_USER)};
    end
endmodule

// File: rtl/sp_bank_regs.sv
module sp_bank_regs #(
    parameter int DATA_W    = 32,
    parameter bit LIMITS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] reset_vector,
    input  logic              main_we,
    input  logic              proc_we,
    input  logic              mlim_we,
    input  logic              plim_we,
    input  logic              use_proc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] main_q,
    output logic [DATA_W-1:0] proc_q,
    output logic [DATA_W-1:0] mlim_q,
    output logic [DATA_W-1:0] plim_q,
    output logic              fault
);
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);
    localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

    logic [DATA_W-1:0] aligned;
    assign aligned = wdata & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n)       main_q <= reset_vector & ALIGN_MASK;
        else if (main_we) main_q <= aligned;
    end

    // process pointer carries no reset value
    always_ff @(posedge clk) begin
        if (proc_we) proc_q <= aligned;
    end

    generate
        if (LIMITS_EN) begin : g_lim
            logic hit;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mlim_q <= '0;
                    plim_q <= '0;
                end else begin
                    if (mlim_we) mlim_q <= aligned;
                    if (plim_we) plim_q <= aligned;
                end
            end
            assign hit = (main_we && !use_proc && (aligned < mlim_q)) ||
                         (proc_we &&  use_proc && (aligned < plim_q));
            always_ff @(posedge clk) begin
                if (!rst_n) fault <= 1'b0;
                else        fault <= hit;
            end
        end else begin : g_nolim
            assign mlim_q = '0;
            assign plim_q = '0;
            assign fault  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sp_bank_select.sv
module sp_bank_select
    import sp_bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter bit LIMITS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              handler_mode,
    input  logic [DATA_W-1:0] reset_vector,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] cur_sp,
    output logic [2:0]        ctrl_bits,
    output logic              privileged,
    output logic              limit_fault
);
    logic              use_proc;
    logic              main_we, proc_we, mlim_we, plim_we, ctrl_we;
    logic [DATA_W-1:0] main_q, proc_q, mlim_q, plim_q;

    always_comb begin
        main_we = wr_en && ((wr_sel == SEL_MAIN) || (wr_sel == SEL_CUR && !use_proc));
        proc_we = wr_en && ((wr_sel == SEL_PROC) || (wr_sel == SEL_CUR &&  use_proc));
        mlim_we = wr_en && (wr_sel == SEL_MLIM);
        plim_we = wr_en && (wr_sel == SEL_PLIM);
        ctrl_we = wr_en && (wr_sel == SEL_CTRL);
    end

    sp_ctrl_fsm u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .handler_mode (handler_mode),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (wr_data[CTRL_W-1:0]),
        .ctrl_bits    (ctrl_bits),
        .privileged   (privileged),
        .use_proc     (use_proc)
    );

    sp_bank_regs #(.DATA_W(DATA_W), .LIMITS_EN(LIMITS_EN)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reset_vector (reset_vector),
        .main_we      (main_we),
        .proc_we      (proc_we),
        .mlim_we      (mlim_we),
        .plim_we      (plim_we),
        .use_proc     (use_proc),
        .wdata        (wr_data),
        .main_q       (main_q),
        .proc_q       (proc_q),
        .mlim_q       (mlim_q),
        .plim_q       (plim_q),
        .fault        (limit_fault)
    );

    assign cur_sp = use_proc ? proc_q : main_q;

    always_comb begin
        case (rd_sel)
            SEL_MAIN: rd_data = main_q;
            SEL_PROC: rd_data = proc_q;
            SEL_CUR:  rd_data = cur_sp;
            SEL_CTRL: rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_bits};
            SEL_MLIM: rd_data = mlim_q;
            SEL_PLIM: rd_data = plim_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sp_bank_checker.sv
module sp_bank_checker #(
    parameter int DATA_W    = 32,
    parameter bit LIMITS_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              handler_mode,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [2:0]        rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] cur_sp,
    input logic [2:0]        ctrl_bits,
    input logic              privileged,
    input logic              limit_fault,
    input logic [DATA_W-1:0] main_q,
    input logic [DATA_W-1:0] proc_q
);
    assert_handler_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> (cur_sp == main_q));

    assert_handler_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> privileged);

    assert_user_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!handler_mode && !privileged) |=> (handler_mode || !privileged));

    assert_main_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        main_q[1:0] == 2'b00);

    assert_proc_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> (proc_q[1:0] == 2'b00));

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |=> (ctrl_bits[1] == $past(ctrl_bits[1])));

    assert_fault_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault |-> $past(wr_en));

    generate
        if (!LIMITS_EN) begin : g_nolim_chk
            assert_nolim_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !limit_fault && ((rd_sel == 3'd4 || rd_sel == 3'd5) -> rd_data == '0));
        end
    endgenerate
endmodule

bind sp_bank_select sp_bank_checker #(.DATA_W(DATA_W), .LIMITS_EN(LIMITS_EN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .handler_mode (handler_mode),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .cur_sp       (cur_sp),
    .ctrl_bits    (ctrl_bits),
    .privileged   (privileged),
    .limit_fault  (limit_fault),
    .main_q       (main_q),
    .proc_q       (proc_q)
);

// File: tb/test_sp_bank_select.sv
module test_sp_bank_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        handler_mode = 1'b0;
    logic [31:0] reset_vector = 32'h2000_1003;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data, cur_sp, rd_data_n, cur_sp_n;
    logic [2:0]  ctrl_bits, ctrl_bits_n;
    logic        privileged, limit_fault, privileged_n, limit_fault_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sp_bank_select i_sp_bank_select (
        .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode), .reset_vector(reset_vector),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .cur_sp(cur_sp), .ctrl_bits(ctrl_bits),
        .privileged(privileged), .limit_fault(limit_fault)
    );

    sp_bank_select #(.LIMITS_EN(1'b0)) i_sp_bank_select_nolim (
        .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode), .reset_vector(reset_vector),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data_n), .cur_sp(cur_sp_n), .ctrl_bits(ctrl_bits_n),
        .privileged(privileged_n), .limit_fault(limit_fault_n)
    );

    typedef struct packed {
        logic        hm;
        logic        we;
        logic [2:0]  sel;
        logic [31:0] wd;
        logic [2:0]  rs;
        logic [31:0] exp_rd;
        logic [31:0] exp_cur;
        logic        exp_priv;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 3'd1, 32'h3000_0007, 3'd1, 32'h3000_0004, 32'h2000_1000, 1'b1}, // R4 align
        '{1'b0, 1'b1, 3'd3, 32'h0000_0002, 3'd3, 32'h0000_0002, 32'h3000_0004, 1'b1}, // R3 proc
        '{1'b0, 1'b1, 3'd2, 32'h3000_0100, 3'd1, 32'h3000_0100, 32'h3000_0100, 1'b1}, // R4 alias
        '{1'b1, 1'b0, 3'd0, 32'h0000_0000, 3'd2, 32'h2000_1000, 32'h2000_1000, 1'b1}, // R2
        '{1'b1, 1'b1, 3'd2, 32'h2000_0F08, 3'd0, 32'h2000_0F08, 32'h2000_0F08, 1'b1}, // R4 alias hm
        '{1'b1, 1'b1, 3'd3, 32'h0000_0000, 3'd3, 32'h0000_0002, 32'h2000_0F08, 1'b1}, // R6
        '{1'b0, 1'b1, 3'd3, 32'h0000_0003, 3'd3, 32'h0000_0003, 32'h3000_0100, 1'b0}, // R5 user
        '{1'b0, 1'b1, 3'd3, 32'h0000_0000, 3'd3, 32'h0000_0003, 32'h3000_0100, 1'b0}, // R7
        '{1'b0, 1'b1, 3'd3, 32'h0000_0004, 3'd3, 32'h0000_0003, 32'h3000_0100, 1'b0}, // R7 fp
        '{1'b1, 1'b1, 3'd3, 32'h0000_0006, 3'd3, 32'h0000_0006, 32'h2000_0F08, 1'b1}, // R7 handler
        '{1'b0, 1'b0, 3'd0, 32'h0000_0000, 3'd3, 32'h0000_0006, 32'h3000_0100, 1'b1}, // R3
        '{1'b0, 1'b1, 3'd3, 32'h0000_0000, 3'd3, 32'h0000_0000, 32'h2000_0F08, 1'b1}, // R6
        '{1'b0, 1'b1, 3'd7, 32'hFFFF_FFFF, 3'd7, 32'h0000_0000, 32'h2000_0F08, 1'b1}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic hm, input logic we, input logic [2:0] sel,
                        input logic [31:0] wd, input logic [2:0] rs);
        handler_mode = hm; wr_en = we; wr_sel = sel; wr_data = wd; rd_sel = rs;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 cur_sp", cur_sp, 32'h2000_1000);
        check("R1 ctrl", {29'd0, ctrl_bits}, 32'd0);
        check("R1 priv", {31'd0, privileged}, 32'd1);
        check("R1 fault", {31'd0, limit_fault}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].hm, VECS[i].we, VECS[i].sel, VECS[i].wd, VECS[i].rs);
            check($sformatf("R8 vec%0d rd", i), rd_data, VECS[i].exp_rd);
            check($sformatf("R2/R3 vec%0d cur", i), cur_sp, VECS[i].exp_cur);
            check($sformatf("R5 vec%0d priv", i), {31'd0, privileged}, {31'd0, VECS[i].exp_priv});
        end

        // R9 / R10 limit behaviour
        step(1'b0, 1'b1, 3'd4, 32'h2000_0800, 3'd4);
        check("R8 main limit read", rd_data, 32'h2000_0800);
        check("R10 nolim read", rd_data_n, 32'd0);
        step(1'b0, 1'b1, 3'd0, 32'h2000_0703, 3'd0);
        check("R9 below limit pulse", {31'd0, limit_fault}, 32'd1);
        check("R4 main aligned", rd_data, 32'h2000_0700);
        check("R10 nolim no fault", {31'd0, limit_fault_n}, 32'd0);
        step(1'b0, 1'b0, 3'd0, 32'd0, 3'd0);
        check("R9 pulse drops", {31'd0, limit_fault}, 32'd0);
        step(1'b0, 1'b1, 3'd2, 32'h2000_0800, 3'd0);
        check("R9 equal no fault", {31'd0, limit_fault}, 32'd0);
        step(1'b0, 1'b1, 3'd5, 32'h3000_0000, 3'd5);
        check("R8 proc limit read", rd_data, 32'h3000_0000);
        step(1'b0, 1'b1, 3'd1, 32'h2FFF_FFF0, 3'd1);
        check("R9 inactive no fault", {31'd0, limit_fault}, 32'd0);
        check("R4 proc write", rd_data, 32'h2FFF_FFF0);
        step(1'b0, 1'b1, 3'd3, 32'h0000_0002, 3'd2);
        check("R3 proc selected", cur_sp, 32'h2FFF_FFF0);
        step(1'b0, 1'b1, 3'd2, 32'h2FFF_FFE0, 3'd1);
        check("R9 proc below limit", {31'd0, limit_fault}, 32'd1);
        check("R10 nolim proc limit read", {31'd0, limit_fault_n}, 32'd0);
        step(1'b0, 1'b0, 3'd0, 32'd0, 3'd5);
        check("R10 nolim plim zero", rd_data_n, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule